// File: doc/BRIEF.md
# Parallel Port Control-Word Decoder

This block is the processor-facing register and decode logic of a programmable parallel I/O peripheral with three 8-bit ports, A, B and C. Port C is split into a high nibble and a low nibble. The block sits on an 8-bit data bus. It has an active-low select line, active-low read and write strobes and a 2-bit address. The address picks port A (0), port B (1), port C (2) or the control register (3). The block holds the control word and the three output latches. It drives a direction enable for each port and for each nibble of port C, and it reports the mode of each of the two port groups. The handshake state machines are separate blocks and take these mode outputs. The pads are modelled as separate drive-value and drive-enable pairs, so the block has no tri-state logic.

A write to the control address is split by data bit 7 into one of two commands. With bit 7 set, the byte is a full configuration word. With bit 7 clear, the byte is an atomic set or clear of one port C bit. All storage is clocked. A write takes effect on the rising clock edge at which select and write are both low and read is high. A read is combinational: it is valid while select and read are low and write is high.

Top module: `ppi_ctrl_decoder`

## Requirements
- R1: A high `rst` at a clock edge loads the control word 0x9B and clears all three output latches. After reset the control address reads 0x9B, every drive enable is 0 and both group modes are 0.
- R2: Nothing is transferred while `cs_n` is high. A write strobe then changes no latch and no control word, and `dout_en` stays 0.
- R3: A control write with bit 7 equal to 1 stores the whole byte. A read of address 3 returns the last configuration word stored.
- R4: In the configuration word, a bit value of 1 means input and 0 means output. Bit 4 sets port A, bit 1 port B, bit 3 the high nibble of port C and bit 0 the low nibble. The matching enable (`pa_en`, `pb_en`, `pc_hi_en`, `pc_lo_en`) is 1 exactly when that part is an output.
- R5: `grp_b_mode` equals bit 2 of the word (0 simple, 1 strobed). `grp_a_mode` decodes bits 6:5: 00 gives 0 (simple), 01 gives 1 (strobed), and 10 or 11 gives 2 (bidirectional).
- R6: A control write with bit 7 equal to 0 sets port C bit number din[3:1] to the value din[0]. Bits 6:4 are ignored. No other port C bit, no other latch and no part of the stored word changes.
- R7: Storing a configuration word clears the port A, B and C output latches to 0.
- R8: A read of a port, or of a port C nibble, returns the latch contents when that part is an output. When that part is an input, the read returns the live pin value at that moment, with no latching.
- R9: A write to a port configured as input still updates its latch, which is visible on its drive-value output, but its drive enable stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | 0 port A, 1 port B, 2 port C, 3 control |
| din | input | 8 | Write data from the processor |
| dout | output | 8 | Read data to the processor |
| dout_en | output | 1 | Bus drive enable for a read |
| pa_pins_in | input | 8 | Live port A pin levels |
| pa_drv | output | 8 | Port A latch value |
| pa_en | output | 1 | Port A drive enable |
| pb_pins_in | input | 8 | Live port B pin levels |
| pb_drv | output | 8 | Port B latch value |
| pb_en | output | 1 | Port B drive enable |
| pc_pins_in | input | 8 | Live port C pin levels |
| pc_drv | output | 8 | Port C latch value |
| pc_hi_en | output | 1 | Drive enable for port C bits 7:4 |
| pc_lo_en | output | 1 | Drive enable for port C bits 3:0 |
| grp_a_mode | output | 2 | Group A mode: 0 simple, 1 strobed, 2 bidirectional |
| grp_b_mode | output | 1 | Group B mode: 0 simple, 1 strobed |

## Verification
The hardest case to reach is a bit command that must leave everything else alone. After each configuration word the latches are cleared, so a bit command has nothing to preserve unless the state is built up first. The stimulus therefore stores an all-output word, fills port A and port B with distinct patterns, and then applies every 7-bit command, with all don't-care combinations. It checks port C against a running bench model after each command and reads back port A and the control word. The mixed-direction reads of port C are reached by sweeping all sixteen direction settings. For each setting the pins change between two reads, so that latched data cannot pass for live data.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int DW       = 8;
    localparam int NIB      = DW / 2;
    localparam int PINSEL_W = $clog2(DW);
    localparam logic [DW-1:0] RESET_WORD = 8'h9B;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_CTRL = 2'd3
    } sel_e;

    typedef enum logic [1:0] {
        GM_SIMPLE  = 2'd0,
        GM_STROBED = 2'd1,
        GM_BIDIR   = 2'd2
    } gmode_e;

    typedef struct packed {
        logic we;
        logic re;
        sel_e sel;
    } bus_t;

    typedef struct packed {
        gmode_e grp_a;
        logic   grp_b;
        logic   a_in;
        logic   cu_in;
        logic   b_in;
        logic   cl_in;
    } cfg_t;

    function automatic cfg_t decode_word(input logic [6:0] w);
        cfg_t c;
        c.a_in  = w[4];
        c.cu_in = w[3];
        c.b_in  = w[1];
        c.cl_in = w[0];
        c.grp_b = w[2];
        if (w[6])      c.grp_a = GM_BIDIR;
        else if (w[5]) c.grp_a = GM_STROBED;
        else           c.grp_a = GM_SIMPLE;
        return c;
    endfunction
endpackage

// File: rtl/ppi_bus_if.sv
module ppi_bus_if
    import ppi_pkg::*;
(
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] addr,
    output bus_t       bus
);
    always_comb begin
        bus.we  = !cs_n && !wr_n && rd_n;
        bus.re  = !cs_n && !rd_n && wr_n;
        bus.sel = sel_e'(addr);
    end
endmodule

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
    import ppi_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bus_t                bus,
    input  logic [DW-1:0]       din,
    output logic [DW-1:0]       word_q,
    output logic                mode_wr,
    output logic                bit_wr,
    output logic [PINSEL_W-1:0] bit_idx,
    output logic                bit_val
);
    logic ctrl_hit;

    always_comb begin
        ctrl_hit = bus.we && (bus.sel == SEL_CTRL);
        mode_wr  = ctrl_hit && din[DW-1];
        bit_wr   = ctrl_hit && !din[DW-1];
        bit_idx  = din[PINSEL_W:1];
        bit_val  = din[0];
    end

    always_ff @(posedge clk) begin
        if (rst)          word_q <= RESET_WORD;
        else if (mode_wr) word_q <= din;
    end
endmodule

// File: rtl/ppi_port_latch.sv
module ppi_port_latch
    import ppi_pkg::*;
#(
    parameter int W      = DW,
    parameter bit BITOPS = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr,
    input  logic [W-1:0]         din,
    input  logic                 bit_wr,
    input  logic [$clog2(W)-1:0] bit_idx,
    input  logic                 bit_val,
    output logic [W-1:0]         q
);
    logic [W-1:0] nxt;

    generate
        if (BITOPS) begin : g_bitops
            always_comb begin
                nxt = q;
                if (clr)         nxt = '0;
                else if (wr)     nxt = din;
                else if (bit_wr) nxt[bit_idx] = bit_val;
            end
        end else begin : g_plain
            logic unused_bits;
            assign unused_bits = bit_wr ^ bit_val ^ (^bit_idx);
            always_comb begin
                nxt = q;
                if (clr)     nxt = '0;
                else if (wr) nxt = din;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/ppi_ctrl_decoder.sv
module ppi_ctrl_decoder
    import ppi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_en,
    input  logic [DW-1:0] pa_pins_in,
    output logic [DW-1:0] pa_drv,
    output logic          pa_en,
    input  logic [DW-1:0] pb_pins_in,
    output logic [DW-1:0] pb_drv,
    output logic          pb_en,
    input  logic [DW-1:0] pc_pins_in,
    output logic [DW-1:0] pc_drv,
    output logic          pc_hi_en,
    output logic          pc_lo_en,
    output logic [1:0]    grp_a_mode,
    output logic          grp_b_mode
);
    bus_t                bus;
    logic [DW-1:0]       ctrl_word;
    logic                mode_wr;
    logic                bit_wr;
    logic [PINSEL_W-1:0] bit_idx;
    logic                bit_val;
    cfg_t                cfg;
    logic [DW-1:0]       pc_view;

    ppi_bus_if u_bus (
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .bus(bus)
    );

    ppi_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .bus(bus), .din(din), .word_q(ctrl_word),
        .mode_wr(mode_wr), .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val)
    );

    ppi_port_latch #(.W(DW), .BITOPS(1'b0)) u_pa (
        .clk(clk), .rst(rst), .clr(mode_wr),
        .wr(bus.we && bus.sel == SEL_A), .din(din),
        .bit_wr(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pa_drv)
    );

    ppi_port_latch #(.W(DW), .BITOPS(1'b0)) u_pb (
        .clk(clk), .rst(rst), .clr(mode_wr),
        .wr(bus.we && bus.sel == SEL_B), .din(din),
        .bit_wr(1'b0), .bit_idx('0), .bit_val(1'b0), .q(pb_drv)
    );

    ppi_port_latch #(.W(DW), .BITOPS(1'b1)) u_pc (
        .clk(clk), .rst(rst), .clr(mode_wr),
        .wr(bus.we && bus.sel == SEL_C), .din(din),
        .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val), .q(pc_drv)
    );

    always_comb begin
        cfg        = decode_word(ctrl_word[DW-2:0]);
        pa_en      = !cfg.a_in;
        pb_en      = !cfg.b_in;
        pc_hi_en   = !cfg.cu_in;
        pc_lo_en   = !cfg.cl_in;
        grp_a_mode = cfg.grp_a;
        grp_b_mode = cfg.grp_b;
        pc_view[DW-1:NIB] = cfg.cu_in ? pc_pins_in[DW-1:NIB] : pc_drv[DW-1:NIB];
        pc_view[NIB-1:0]  = cfg.cl_in ? pc_pins_in[NIB-1:0]  : pc_drv[NIB-1:0];
        dout_en = bus.re;
        unique case (bus.sel)
            SEL_A:   dout = cfg.a_in ? pa_pins_in : pa_drv;
            SEL_B:   dout = cfg.b_in ? pb_pins_in : pb_drv;
            SEL_C:   dout = pc_view;
            default: dout = ctrl_word;
        endcase
    end
endmodule

// File: rtl/ppi_ctrl_checker.sv
module ppi_ctrl_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic       dout_en,
    input logic [7:0] pa_pins_in,
    input logic       pa_en,
    input logic [7:0] pa_drv,
    input logic [7:0] pb_drv,
    input logic [7:0] pc_drv,
    input logic [7:0] word
);
    logic ctrl_wr;
    assign ctrl_wr = !cs_n && !wr_n && rd_n && (addr == 2'd3);

    a_r1_reset_word: assert property (@(posedge clk)
        rst |=> (word == 8'h9B && pa_drv == 8'h00 && pc_drv == 8'h00));

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> ($stable(pa_drv) && $stable(pb_drv) && $stable(pc_drv) && $stable(word)));

    a_r6_single_bit: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !din[7]) |=> ($countones(pc_drv ^ $past(pc_drv)) <= 1
                                  && $stable(word) && $stable(pa_drv) && $stable(pb_drv)));

    a_r7_mode_clears: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && din[7]) |=> (pa_drv == 8'h00 && pb_drv == 8'h00 && pc_drv == 8'h00
                                 && word == $past(din)));

    a_r8_live_read: assert property (@(posedge clk) disable iff (rst)
        (dout_en && addr == 2'd0 && !pa_en) |-> (dout == pa_pins_in));
endmodule

bind ppi_ctrl_decoder ppi_ctrl_checker u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_en(dout_en), .pa_pins_in(pa_pins_in),
    .pa_en(pa_en), .pa_drv(pa_drv), .pb_drv(pb_drv), .pc_drv(pc_drv),
    .word(ctrl_word)
);

// File: tb/ppi_ctrl_decoder_bench.sv
module ppi_ctrl_decoder_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_en;
    logic [7:0] pa_pins_in = 8'h00, pb_pins_in = 8'h00, pc_pins_in = 8'h00;
    logic [7:0] pa_drv, pb_drv, pc_drv;
    logic       pa_en, pb_en, pc_hi_en, pc_lo_en;
    logic [1:0] grp_a_mode;
    logic       grp_b_mode;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_pc;

    always #4 clk = ~clk;

    ppi_ctrl_decoder u_ppi_ctrl_decoder (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .din(din), .dout(dout), .dout_en(dout_en),
        .pa_pins_in(pa_pins_in), .pa_drv(pa_drv), .pa_en(pa_en),
        .pb_pins_in(pb_pins_in), .pb_drv(pb_drv), .pb_en(pb_en),
        .pc_pins_in(pc_pins_in), .pc_drv(pc_drv),
        .pc_hi_en(pc_hi_en), .pc_lo_en(pc_lo_en),
        .grp_a_mode(grp_a_mode), .grp_b_mode(grp_b_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; addr = a; din = d;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1;
        chk(tag, {23'd0, dout_en, dout}, {23'd0, 1'b1, exp});
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    function automatic logic [1:0] ga_exp(input logic [7:0] w);
        return w[6] ? 2'd2 : (w[5] ? 2'd1 : 2'd0);
    endfunction

    initial begin : watchdog
        #1000000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        chk("R1 enables", {pa_en, pb_en, pc_hi_en, pc_lo_en}, 4'b0000);
        chk("R1 modes", {grp_a_mode, grp_b_mode}, 3'b000);
        chk("R1 latches", {pa_drv, pb_drv, pc_drv}, 24'h0);
        bus_rd(2'd3, 8'h9B, "R1 control readback");

        // R2 unselected write and read
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b0; addr = 2'd0; din = 8'hA5;
        @(negedge clk);
        addr = 2'd3; din = 8'h80;
        @(negedge clk);
        wr_n = 1'b1;
        chk("R2 no latch write", pa_drv, 8'h00);
        chk("R2 no ctrl write", pa_en, 1'b0);
        rd_n = 1'b0; #1;
        chk("R2 no read drive", dout_en, 1'b0);
        @(negedge clk); rd_n = 1'b1;

        // R3 R4 R5 R7 sweep of every configuration word
        for (int w = 8'h80; w <= 8'hFF; w++) begin
            bus_wr(2'd0, 8'h3C);
            bus_wr(2'd1, 8'hC3);
            bus_wr(2'd2, 8'h99);
            bus_wr(2'd3, w[7:0]);
            chk("R4 direction enables", {pa_en, pb_en, pc_hi_en, pc_lo_en},
                {~w[4], ~w[1], ~w[3], ~w[0]});
            chk("R5 group modes", {grp_a_mode, grp_b_mode}, {ga_exp(w[7:0]), w[2]});
            chk("R7 latches cleared", {pa_drv, pb_drv, pc_drv}, 24'h0);
            bus_rd(2'd3, w[7:0], "R3 control readback");
        end

        // R6 every bit command on an all-output configuration
        bus_wr(2'd3, 8'h80);
        bus_wr(2'd0, 8'h5A);
        bus_wr(2'd1, 8'hE7);
        exp_pc = 8'h00;
        for (int v = 0; v < 128; v++) begin
            bus_wr(2'd3, v[7:0]);
            exp_pc[v[3:1]] = v[0];
            chk("R6 port C bit", pc_drv, exp_pc);
            chk("R6 others untouched", {pa_drv, pb_drv}, 16'h5AE7);
        end
        bus_rd(2'd3, 8'h80, "R6 word unchanged");

        // R8 reads across all direction settings, pins changed between reads
        for (int d = 0; d < 16; d++) begin
            logic [7:0] w, pcx;
            w = {3'b100, d[3], d[2], 1'b0, d[1], d[0]};
            bus_wr(2'd3, w);
            bus_wr(2'd0, 8'h12);
            bus_wr(2'd1, 8'h34);
            bus_wr(2'd2, 8'h56);
            for (int p = 0; p < 2; p++) begin
                pa_pins_in = p[0] ? 8'hF0 : 8'h0F;
                pb_pins_in = p[0] ? 8'hAA : 8'h55;
                pc_pins_in = p[0] ? 8'hC9 : 8'h3E;
                pcx[7:4] = w[3] ? pc_pins_in[7:4] : 4'h5;
                pcx[3:0] = w[0] ? pc_pins_in[3:0] : 4'h6;
                bus_rd(2'd0, w[4] ? pa_pins_in : 8'h12, "R8 port A read");
                bus_rd(2'd1, w[1] ? pb_pins_in : 8'h34, "R8 port B read");
                bus_rd(2'd2, pcx, "R8 port C read");
            end
            // R9 latch written while input, not driven
            chk("R9 latch holds write", {pa_drv, pb_drv, pc_drv}, 24'h123456);
            chk("R9 enables", {pa_en, pb_en, pc_hi_en, pc_lo_en},
                {~w[4], ~w[1], ~w[3], ~w[0]});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule